// File: doc/BRIEF.md
# Gray-Coded Column Timestamp Counter with Pixel Capture

This block sits at the foot of a pixel column. It runs a single Gray-coded time counter and fans that code out to a row of pixel capture cells. A conversion-start strobe clears the counter. The counter then moves forward by one code step per clock for the rest of the conversion. Here one clock stands for one half period of the real dual-edge clock.

Each pixel owns a stop input, which is driven in the real circuit by its comparator. The first rising edge of that stop after a start freezes the code that is on the bus at that moment. Only one bit of the code changes per step, so a capture near a step boundary always yields either the old code or the new one.

The captured Gray value is turned into binary by a prefix XOR. For a slow mode, where the counter is allowed to wrap once, each pixel also builds a ninth result bit. It does this by watching the top counter bit fall after its first rise.

Top module: `gray_stamp_column`

## Requirements
- R1: While reset is low, the counter bus reads 0, every pixel hit flag is 0 and every pixel code is 0. No pixel captures anything until the first start strobe has been seen.
- R2: Outside a start cycle, the bus moves one step per clock through the Gray sequence, code = n XOR (n >> 1) for step index n modulo 256. Exactly one bus bit differs between consecutive steps.
- R3: A start strobe sampled high on a clock edge makes the bus read 0 after that edge. Counting then resumes from 1 on the next edge.
- R4: Bus bit 0 changes at every second step, so its period is four steps, one quarter of the step rate.
- R5: The first rising edge of a pixel's stop after a start sets that pixel's hit flag. The pixel code, bits [7:0] of its 9-bit field, becomes the binary step index of the bus value present in the cycle the edge was sampled.
- R6: Once a pixel has captured, further stop edges in the same conversion are ignored and its code is held. A new start clears the hit flag but leaves the held code in place.
- R7: A stop edge sampled in the same cycle as a start strobe is ignored. A stop level held high across a start is not a new edge and captures nothing.
- R8: With the slow-mode input high at capture, field bit 8 is 1 exactly when the capture falls at step 256 or later, that is after the top bus bit has gone from 1 back to 0. This holds within the first 512 steps. With the slow-mode input low, bit 8 is 0.
- R9: In slow mode, a sweep of captures over steps 0 to 511 yields codes 0 to 511 in order, each one greater than the one before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Step clock, one edge per code step |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_start | input | 1 | Conversion start strobe, clears counter and rearms pixels |
| slow_mode | input | 1 | Enables the ninth result bit for the wrapping slow mode |
| pix_stop | input | NPIX | Per-pixel stop event, captured on its rising edge |
| gray_bus | output | CNT_W | Broadcast Gray counter code |
| pix_hit | output | NPIX | Per-pixel flag, set once a capture has happened in this conversion |
| pix_code | output | NPIX*(CNT_W+1) | Per-pixel binary result, pixel p in bits [p*9 +: 9], bit 8 of each field the ninth bit |

## Verification
Two things can land on the same clock edge. A start strobe can coincide with a stop edge, and a capture can coincide with the top counter bit falling at step 256. The bench raises a pixel's stop in the very cycle it drives the start strobe, and keeps another stop high across a start. It then expects both hit flags to stay low. It also stops a pixel exactly at step 256, and next to that at 255, and expects bit 8 to turn on only for the later one. A behavioural step-index model compares the bus, the hit flags and the codes on every clock, which covers all of these cases.

// File: rtl/gray_stamp_pkg.sv
// Shared types and code helpers for the Gray timestamp column.
// Assumes counter widths of at most 32 bits.
package gray_stamp_pkg;

    // Lifecycle of one pixel capture cell within a conversion.
    typedef enum logic [1:0] {
        PIX_IDLE  = 2'd0,
        PIX_ARMED = 2'd1,
        PIX_DONE  = 2'd2
    } pix_phase_e;

    // Binary to reflected Gray code.
    function automatic logic [31:0] bin2gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

endpackage

// File: rtl/gray_to_bin.sv
// Gray to binary converter built as a prefix XOR chain running from the MSB down.
// Purely combinational. Assumes a reflected Gray code input.
module gray_to_bin #(
    parameter int W = 8
) (
    input  logic [W-1:0] gray_i,
    output logic [W-1:0] bin_o
);
    // Top bit passes straight through.
    assign bin_o[W-1] = gray_i[W-1];

    // Each lower bit is the XOR of the bit above it and its own Gray bit.
    for (genvar i = W - 2; i >= 0; i--) begin : g_chain
        assign bin_o[i] = bin_o[i+1] ^ gray_i[i];
    end

    // R9
    always_comb begin
        conv_inverse_chk: assert ((bin_o ^ (bin_o >> 1)) == gray_i)
            else $error("gray_to_bin: output does not map back to input");
    end
endmodule

// File: rtl/gray_stamp_counter.sv
// Column time counter: a binary step counter with a registered Gray image on the bus.
// One clock edge stands for one half period of the physical dual-edge clock.
// Assumes conv_start is synchronous to clk.
module gray_stamp_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_start_i,
    output logic [CNT_W-1:0] gray_o
);
    import gray_stamp_pkg::*;

    logic [CNT_W-1:0] bin_q, bin_nxt, gray_q;

    // Next step: clear on start, otherwise advance by one.
    always_comb bin_nxt = conv_start_i ? '0 : bin_q + CNT_W'(1);

    // Step register and glitch-free Gray register driving the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bin_q  <= '0;
            gray_q <= '0;
        end else begin
            bin_q  <= bin_nxt;
            gray_q <= CNT_W'(bin2gray(32'(bin_nxt)));
        end
    end

    assign gray_o = gray_q;

    // R2
    one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(conv_start_i) |-> $countones(gray_q ^ $past(gray_q)) == 1);

    // R3
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_i |=> gray_q == '0);

    // R4
    lsb_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(conv_start_i) && !conv_start_i && gray_q[0] != $past(gray_q[0])
        |=> gray_q[0] == $past(gray_q[0]));
endmodule

// File: rtl/gray_stamp_pixel.sv
// One pixel capture cell. It freezes the Gray bus on the first stop rising edge after a start.
// It also follows the bus MSB to build a ninth bit marking one counter wrap.
// Assumes stop_i has already been brought into the clk domain.
// Assumes the slow mode keeps captures within two counter periods.
module gray_stamp_pixel #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_start_i,
    input  logic             slow_mode_i,
    input  logic             stop_i,
    input  logic [CNT_W-1:0] gray_bus_i,
    output logic             hit_o,
    output logic [CNT_W:0]   code_o
);
    import gray_stamp_pkg::*;

    localparam int MSB = CNT_W - 1;

    pix_phase_e       phase_q;
    logic             stop_q;
    logic             msb_seen_q;
    logic             wrapped_q;
    logic [CNT_W-1:0] cap_gray_q;
    logic             cap_ninth_q;
    logic [CNT_W-1:0] cap_bin;
    logic             stop_edge;
    logic             wrap_now;
    logic             capture;

    assign stop_edge = stop_i & ~stop_q;
    assign wrap_now  = wrapped_q | (msb_seen_q & ~gray_bus_i[MSB]);
    assign capture   = (phase_q == PIX_ARMED) && stop_edge && !conv_start_i;

    // Previous stop level, used to find rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n) stop_q <= 1'b0;
        else        stop_q <= stop_i;
    end

    // Phase: a start arms the cell, the first capture completes it.
    always_ff @(posedge clk) begin
        if (!rst_n)            phase_q <= PIX_IDLE;
        else if (conv_start_i) phase_q <= PIX_ARMED;
        else if (capture)      phase_q <= PIX_DONE;
    end

    // MSB watcher: note the first MSB rise, then its later fall, which is the wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || conv_start_i) begin
            msb_seen_q <= 1'b0;
            wrapped_q  <= 1'b0;
        end else if (phase_q == PIX_ARMED) begin
            msb_seen_q <= msb_seen_q | gray_bus_i[MSB];
            wrapped_q  <= wrap_now;
        end
    end

    // Capture registers: the frozen code and its ninth bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_gray_q  <= '0;
            cap_ninth_q <= 1'b0;
        end else if (capture) begin
            cap_gray_q  <= gray_bus_i;
            cap_ninth_q <= slow_mode_i & wrap_now;
        end
    end

    gray_to_bin #(.W(CNT_W)) u_conv (
        .gray_i (cap_gray_q),
        .bin_o  (cap_bin)
    );

    assign hit_o  = (phase_q == PIX_DONE);
    assign code_o = {cap_ninth_q, cap_bin};

    // R5
    hit_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hit_o) |-> $past(stop_i));

    // R6
    cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o && !conv_start_i |=> $stable(cap_gray_q) && $stable(cap_ninth_q));

    // R7
    start_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_i |=> !hit_o);

    // R8
    fast_ninth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hit_o) && !$past(slow_mode_i) |-> !cap_ninth_q);

    // R8
    wrap_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrapped_q && !conv_start_i |=> wrapped_q);
endmodule

// File: rtl/gray_stamp_column.sv
// Column top: one Gray time counter broadcasting to NPIX pixel capture cells.
// Assumes all inputs are synchronous to clk. Pixel p result sits in pix_code[p*(CNT_W+1) +: CNT_W+1].
module gray_stamp_column #(
    parameter int CNT_W = 8,
    parameter int NPIX  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      conv_start,
    input  logic                      slow_mode,
    input  logic [NPIX-1:0]           pix_stop,
    output logic [CNT_W-1:0]          gray_bus,
    output logic [NPIX-1:0]           pix_hit,
    output logic [NPIX*(CNT_W+1)-1:0] pix_code
);
    localparam int CODE_W = CNT_W + 1;

    gray_stamp_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .conv_start_i (conv_start),
        .gray_o       (gray_bus)
    );

    // One capture cell per pixel on the shared bus.
    for (genvar p = 0; p < NPIX; p++) begin : g_pix
        gray_stamp_pixel #(.CNT_W(CNT_W)) u_pix (
            .clk          (clk),
            .rst_n        (rst_n),
            .conv_start_i (conv_start),
            .slow_mode_i  (slow_mode),
            .stop_i       (pix_stop[p]),
            .gray_bus_i   (gray_bus),
            .hit_o        (pix_hit[p]),
            .code_o       (pix_code[p*CODE_W +: CODE_W])
        );
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> gray_bus == '0 && pix_hit == '0);
endmodule

// File: tb/gray_stamp_column_test.sv
`timescale 1ns/1ps
module gray_stamp_column_test;
    localparam int CNT_W = 8;
    localparam int NPIX  = 8;
    localparam int CW    = CNT_W + 1;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 conv_start = 1'b0;
    logic                 slow_mode = 1'b0;
    logic [NPIX-1:0]      pix_stop = '0;
    logic [CNT_W-1:0]     gray_bus;
    logic [NPIX-1:0]      pix_hit;
    logic [NPIX*CW-1:0]   pix_code;

    int total = 0;
    int bad = 0;
    bit cmp_en = 0;
    bit done = 0;

    // Reference model state, behavioural
    int m_cnt = 0;
    int m_steps = 0;
    bit m_armed[NPIX];
    bit m_hit[NPIX];
    int m_code[NPIX];
    bit m_prev[NPIX];
    int sweep_res[512];

    gray_stamp_column #(.CNT_W(CNT_W), .NPIX(NPIX)) uut (
        .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .slow_mode(slow_mode),
        .pix_stop(pix_stop), .gray_bus(gray_bus), .pix_hit(pix_hit), .pix_code(pix_code)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int code_of(input int p);
        return int'(pix_code[p*CW +: CW]);
    endfunction

    // Model update on every rising edge from pre-edge inputs
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_steps = 0;
            for (int p = 0; p < NPIX; p++) begin
                m_armed[p] = 0; m_hit[p] = 0; m_code[p] = 0; m_prev[p] = 0;
            end
        end else begin
            for (int p = 0; p < NPIX; p++) begin
                if (conv_start) begin
                    m_armed[p] = 1; m_hit[p] = 0;
                end else if (m_armed[p] && pix_stop[p] && !m_prev[p]) begin
                    m_armed[p] = 0; m_hit[p] = 1;
                    m_code[p] = slow_mode ? (m_steps % 512) : (m_steps % 256);
                end
                m_prev[p] = pix_stop[p];
            end
            m_cnt   = conv_start ? 0 : (m_cnt + 1) % 256;
            m_steps = conv_start ? 0 : m_steps + 1;
        end
    end

    // Compare outputs against the model on every falling edge
    always @(negedge clk) begin
        if (cmp_en) begin
            chk(int'(gray_bus) == (m_cnt ^ (m_cnt >> 1)), "R2 bus code", int'(gray_bus), m_cnt ^ (m_cnt >> 1));
            for (int p = 0; p < NPIX; p++) begin
                chk(pix_hit[p] == m_hit[p], "R5 hit flag", int'(pix_hit[p]), int'(m_hit[p]));
                chk(code_of(p) == m_code[p], "R5 pixel code", code_of(p), m_code[p]);
            end
        end
    end

    task automatic start_conv();
        @(negedge clk);
        conv_start = 1'b1;
        pix_stop = '0;
        @(negedge clk);
        conv_start = 1'b0;
    endtask

    // Runs a conversion, raising pixel p's stop when the bus shows step stop_at[p]
    task automatic run_conv(input int stop_at[NPIX], input int last);
        start_conv();
        for (int s = 0; s <= last; s++) begin
            for (int p = 0; p < NPIX; p++)
                if (s == stop_at[p]) pix_stop[p] = 1'b1;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    initial begin
        int at[NPIX];
        int toggles;
        logic prev_b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(gray_bus == '0, "R1 bus in reset", int'(gray_bus), 0);
        chk(pix_hit == '0, "R1 hits in reset", int'(pix_hit), 0);
        chk(pix_code == '0, "R1 codes in reset", int'(pix_code[31:0]), 0);
        rst_n = 1'b1;
        cmp_en = 1;
        // R1 no capture before the first start
        pix_stop[0] = 1'b1;
        repeat (3) @(negedge clk);
        chk(pix_hit[0] == 1'b0, "R1 no capture before start", int'(pix_hit[0]), 0);

        // R3 clear and R4 bit 0 rate
        start_conv();
        chk(gray_bus == '0, "R3 bus cleared", int'(gray_bus), 0);
        toggles = 0;
        prev_b0 = gray_bus[0];
        for (int s = 1; s <= 16; s++) begin
            @(negedge clk);
            if (gray_bus[0] != prev_b0) toggles++;
            chk(gray_bus[0] == 1'(((s + 1) >> 1) & 1), "R4 bit0 pattern", int'(gray_bus[0]), ((s + 1) >> 1) & 1);
            prev_b0 = gray_bus[0];
        end
        chk(toggles == 8, "R4 bit0 toggle count", toggles, 8);

        // R5 captures in fast mode, R6 repeated stops, R7 coincident start
        slow_mode = 1'b0;
        for (int p = 0; p < NPIX; p++) at[p] = 1000;
        at[0] = 0; at[2] = 17; at[3] = 200; at[4] = 300;
        @(negedge clk);
        conv_start = 1'b1;
        pix_stop = '0;
        pix_stop[1] = 1'b1;            // stop edge in the start cycle
        @(negedge clk);
        conv_start = 1'b0;
        for (int s = 0; s <= 310; s++) begin
            for (int p = 0; p < NPIX; p++)
                if (s == at[p]) pix_stop[p] = 1'b1;
            if (s == 40) pix_stop[2] = 1'b0;
            if (s == 45) pix_stop[2] = 1'b1;   // second edge, ignored
            @(negedge clk);
        end
        @(negedge clk);
        chk(code_of(0) == 0, "R5 capture at step 0", code_of(0), 0);
        chk(code_of(2) == 17, "R6 first edge kept", code_of(2), 17);
        chk(code_of(3) == 200, "R5 capture at step 200", code_of(3), 200);
        chk(code_of(4) == 44, "R8 fast mode wraps, bit 8 clear", code_of(4), 44);
        chk(pix_hit[1] == 1'b0, "R7 edge with start ignored", int'(pix_hit[1]), 0);

        // R7 level held across a start; R6 hit cleared, code kept
        @(negedge clk);
        conv_start = 1'b1;
        pix_stop = '0;
        pix_stop[3] = 1'b1;
        @(negedge clk);
        conv_start = 1'b0;
        chk(pix_hit[2] == 1'b0 && code_of(2) == 17, "R6 start clears hit keeps code", code_of(2), 17);
        repeat (20) @(negedge clk);
        chk(pix_hit[3] == 1'b0, "R7 held level not an edge", int'(pix_hit[3]), 0);

        // R8 slow mode around the wrap
        slow_mode = 1'b1;
        for (int p = 0; p < NPIX; p++) at[p] = 1000;
        at[0] = 255; at[1] = 256; at[2] = 300; at[3] = 130; at[4] = 511;
        run_conv(at, 511);
        chk(code_of(0) == 255, "R8 step 255 no ninth bit", code_of(0), 255);
        chk(code_of(1) == 256, "R8 step 256 ninth bit", code_of(1), 256);
        chk(code_of(2) == 300, "R8 step 300", code_of(2), 300);
        chk(code_of(3) == 130, "R8 step 130", code_of(3), 130);
        chk(code_of(4) == 511, "R8 step 511", code_of(4), 511);

        // R9 sweep over all 512 slow-mode steps
        for (int c = 0; c < 64; c++) begin
            for (int p = 0; p < NPIX; p++) at[p] = c + 64 * p;
            run_conv(at, c + 64 * (NPIX - 1));
            for (int p = 0; p < NPIX; p++) sweep_res[c + 64 * p] = code_of(p);
        end
        for (int i = 0; i < 512; i++)
            chk(sweep_res[i] == i, "R9 sweep value", sweep_res[i], i);
        for (int i = 0; i < 511; i++)
            chk(sweep_res[i + 1] > sweep_res[i], "R9 sweep monotonic", sweep_res[i + 1], sweep_res[i] + 1);

        cmp_en = 0;
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL all: watchdog actual=%0d expected=%0d", 200000, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule